// File: doc/BRIEF.md
# Interrupt Source Presented/Queued State Controller

This block keeps a table of interrupt sources. Each source holds a two-bit state, Presented (P) and Queued (Q), and a flag that marks it as a level source instead of a message source. Trigger events (assert or deassert) and end-of-interrupt (EOI) events change a source's state. When the new state calls for delivery, the block sends a one-cycle present request with the source number to a downstream presentation controller. With this state, a message interrupt that arrives while its source is already presented is held in Q rather than dropped. The EOI then promotes the held interrupt to P and presents it again, so each arrival leads to exactly one delivery.

A save/restore port reads and writes one source's state as a 64-bit record. Software uses it to move the table across a context switch. Arbitration, routing, masking and the presentation controller lie outside this block.

Trigger-driven presents appear on one output channel and EOI-driven presents on a second channel. Two presents for different sources in the same cycle therefore both reach the presentation controller.

Top module: `irqPqController`

## Requirements
- R1: After reset every source is a message source with P=0 and Q=0, so every saved record reads zero. Neither present channel nor the error strobe is active.
- R2: A trigger assert on a message source in state P=0,Q=0 leaves it with P=1,Q=0. In the next cycle it raises trigPresValid for exactly one cycle, with trigPresSrc equal to the source number. State bit 0 is P and bit 1 is Q.
- R3: A message trigger assert sets the new state to Q = old P and P = 1. A present is issued only when the new state is exactly P=1,Q=0, so a trigger on a source that is already presented sets Q and does not present.
- R4: A message EOI shifts the state right by one, moving Q into P and clearing Q. If P is then 1, the block raises eoiPresValid with eoiPresSrc in the next cycle.
- R5: A level assert on a source whose P is 1 changes nothing and does not present. Otherwise it sets the state to P=1,Q=0 and presents on the trigger channel.
- R6: A deassert on a level source clears P and Q. A deassert on a message source has no effect.
- R7: A level EOI leaves the state unchanged and presents on the EOI channel if P is 1.
- R8: The source number of an EOI is bits 23:0 of eoiWord, and bits 31:24 are ignored. An EOI whose source number equals the parameter IPI_NUM (default 2) changes no state and raises no present or error.
- R9: saveRecord shows the state of source saveSrc with bit 40 = level, bit 41 = masked (always 0), bit 42 = pending (level and P), bit 43 = P and bit 44 = Q. All other bits are 0, and a source number outside the table reads as zero.
- R10: A restore writes the level flag from bit 40, sets P from bit 43 OR bit 42 and sets Q from bit 44. The written state shows on saveRecord from the next cycle.
- R11: When a trigger and an EOI name the same source in one cycle, the EOI update is applied first and the trigger acts on its result. Each step presents on its own channel, and a restore in the same cycle overrides the resulting state.
- R12: A trigger, non-inter-processor EOI or restore naming a source at or above NUM_SRC changes no state. It raises errStrobe for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | Trigger event strobe |
| trigAssert | input | 1 | 1 = assert, 0 = deassert |
| trigSrc | input | 24 | Trigger source number |
| eoiValid | input | 1 | EOI event strobe |
| eoiWord | input | 32 | EOI word; source number in bits 23:0 |
| restoreValid | input | 1 | Restore strobe |
| restoreSrc | input | 24 | Source to restore |
| restoreRecord | input | 64 | Record to unpack |
| saveSrc | input | 24 | Source to read |
| saveRecord | output | 64 | Packed record of saveSrc |
| trigPresValid | output | 1 | Present request caused by a trigger |
| trigPresSrc | output | 24 | Source of the trigger-channel present |
| eoiPresValid | output | 1 | Present request caused by an EOI |
| eoiPresSrc | output | 24 | Source of the EOI-channel present |
| errStrobe | output | 1 | Out-of-range event seen one cycle earlier |

## Verification
A trigger and an EOI can name the same source in one cycle. The bench drives both strobes together on a message source in each P/Q state and checks the ordered result. In state P=1,Q=1 the EOI presents and the trigger then queues. In state P=1,Q=0 the EOI clears P and the trigger presents again. The bench also pairs a trigger and an EOI on different sources in one cycle, expects a present on each channel in the following cycle, and confirms the final state of each source through the save port.

// File: rtl/irqPqPkg.sv
package irqPqPkg;
  localparam int SRC_NUM_W = 24;
  localparam int REC_W     = 64;

  // Per-source state: bit 0 presented, bit 1 queued
  localparam logic [1:0] PQ_IDLE = 2'b00;
  localparam logic [1:0] PQ_PRES = 2'b01;

  // Save/restore record bit positions
  localparam int REC_LEVEL = 40;
  localparam int REC_MASK  = 41;
  localparam int REC_PEND  = 42;
  localparam int REC_PRES  = 43;
  localparam int REC_QUEUE = 44;

  typedef logic [SRC_NUM_W-1:0] srcNumT;

  typedef struct packed {
    logic       trigEn;
    logic       trigAssert;
    srcNumT     trigIdx;
    logic       eoiEn;
    srcNumT     eoiIdx;
    logic       rstrEn;
    srcNumT     rstrIdx;
    logic       rstrLevel;
    logic [1:0] rstrPq;
  } pqStrobeT;
endpackage

// File: rtl/irqPqDecode.sv
module irqPqDecode
  import irqPqPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IPI_NUM = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigValid,
  input  logic               trigAssert,
  input  logic [23:0]        trigSrc,
  input  logic               eoiValid,
  input  logic [31:0]        eoiWord,
  input  logic               restoreValid,
  input  logic [23:0]        restoreSrc,
  input  logic [REC_W-1:0]   restoreRecord,
  output pqStrobeT           strb,
  output logic               errStrobe
);
  srcNumT eoiSrc;
  logic   eoiLive, trigOk, eoiOk, rstrOk, errNext;
  logic   unusedBits;

  assign unusedBits = ^{eoiWord[31:24], restoreRecord[REC_W-1:REC_QUEUE+1],
                        restoreRecord[REC_MASK], restoreRecord[REC_LEVEL-1:0]};

  always_comb begin
    eoiSrc  = eoiWord[SRC_NUM_W-1:0];
    eoiLive = eoiValid && (eoiSrc != srcNumT'(IPI_NUM));
    trigOk  = trigSrc    < srcNumT'(NUM_SRC);
    eoiOk   = eoiSrc     < srcNumT'(NUM_SRC);
    rstrOk  = restoreSrc < srcNumT'(NUM_SRC);

    strb.trigEn     = trigValid && trigOk;
    strb.trigAssert = trigAssert;
    strb.trigIdx    = trigSrc;
    strb.eoiEn      = eoiLive && eoiOk;
    strb.eoiIdx     = eoiSrc;
    strb.rstrEn     = restoreValid && rstrOk;
    strb.rstrIdx    = restoreSrc;
    strb.rstrLevel  = restoreRecord[REC_LEVEL];
    strb.rstrPq     = {restoreRecord[REC_QUEUE],
                       restoreRecord[REC_PRES] | restoreRecord[REC_PEND]};

    errNext = (trigValid && !trigOk) || (eoiLive && !eoiOk) ||
              (restoreValid && !rstrOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errStrobe <= 1'b0;
    else       errStrobe <= errNext;
  end

  // R8: an EOI naming the inter-processor number never reaches the table
  a_r8_ipi_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && eoiWord[23:0] == 24'(IPI_NUM)) |-> !strb.eoiEn);

  // R12: an out-of-range trigger raises the error strobe next cycle
  a_r12_trig_err: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && trigSrc >= 24'(NUM_SRC)) |=> errStrobe);
endmodule

// File: rtl/irqPqTable.sv
module irqPqTable
  import irqPqPkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pqStrobeT         strb,
  input  logic [23:0]      saveSrc,
  output logic [REC_W-1:0] saveRecord,
  output logic             trigPresValid,
  output logic [23:0]      trigPresSrc,
  output logic             eoiPresValid,
  output logic [23:0]      eoiPresSrc
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]         pq       [NUM_SRC];
  logic [NUM_SRC-1:0] lvl;
  logic [1:0]         afterEoi [NUM_SRC];
  logic [1:0]         afterTrig[NUM_SRC];
  logic [NUM_SRC-1:0] trigPresVec, eoiPresVec;
  logic [IDX_W-1:0]   saveIdx;

  // Per-source next state: EOI step first, then trigger step on its result
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      afterEoi[i]   = pq[i];
      eoiPresVec[i] = 1'b0;
      if (strb.eoiEn && strb.eoiIdx == srcNumT'(i)) begin
        if (!lvl[i]) afterEoi[i] = {1'b0, pq[i][1]};
        eoiPresVec[i] = afterEoi[i][0];
      end
      afterTrig[i]   = afterEoi[i];
      trigPresVec[i] = 1'b0;
      if (strb.trigEn && strb.trigIdx == srcNumT'(i)) begin
        if (lvl[i]) begin
          if (!strb.trigAssert) begin
            afterTrig[i] = PQ_IDLE;
          end else if (!afterEoi[i][0]) begin
            afterTrig[i]   = PQ_PRES;
            trigPresVec[i] = 1'b1;
          end
        end else if (strb.trigAssert) begin
          afterTrig[i]   = {afterEoi[i][0], 1'b1};
          trigPresVec[i] = (afterTrig[i] == PQ_PRES);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) pq[i] <= PQ_IDLE;
      lvl           <= '0;
      trigPresValid <= 1'b0;
      trigPresSrc   <= '0;
      eoiPresValid  <= 1'b0;
      eoiPresSrc    <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strb.rstrEn && strb.rstrIdx == srcNumT'(i)) begin
          pq[i]  <= strb.rstrPq;
          lvl[i] <= strb.rstrLevel;
        end else begin
          pq[i] <= afterTrig[i];
        end
      end
      trigPresValid <= |trigPresVec;
      trigPresSrc   <= strb.trigIdx;
      eoiPresValid  <= |eoiPresVec;
      eoiPresSrc    <= strb.eoiIdx;
    end
  end

  // Save port: pack the addressed source's state
  always_comb begin
    saveIdx    = saveSrc[IDX_W-1:0];
    saveRecord = '0;
    if (saveSrc < srcNumT'(NUM_SRC)) begin
      saveRecord[REC_LEVEL] = lvl[saveIdx];
      saveRecord[REC_PEND]  = lvl[saveIdx] & pq[saveIdx][0];
      saveRecord[REC_PRES]  = pq[saveIdx][0];
      saveRecord[REC_QUEUE] = pq[saveIdx][1];
    end
  end

  // R3: a trigger-channel present leaves its source in state P only
  a_r3_pres_exact: assert property (@(posedge clk) disable iff (!rstN)
    (trigPresValid && !$past(strb.rstrEn)) |->
      pq[trigPresSrc[IDX_W-1:0]] == PQ_PRES);

  // R4: an EOI-channel present implies P set unless later steps overrode it
  a_r4_eoi_pres_p: assert property (@(posedge clk) disable iff (!rstN)
    (eoiPresValid && !$past(strb.rstrEn) && !$past(strb.trigEn)) |->
      pq[eoiPresSrc[IDX_W-1:0]][0]);

  // R5: a level assert on a presented source does not present again
  a_r5_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trigEn && strb.trigAssert && lvl[strb.trigIdx[IDX_W-1:0]] &&
     pq[strb.trigIdx[IDX_W-1:0]][0] && !strb.eoiEn) |=> !trigPresValid);

  // R11: one source never presents on both channels in the same cycle
  a_r11_single_pres: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trigEn && strb.eoiEn && strb.trigIdx == strb.eoiIdx) |=>
      !(trigPresValid && eoiPresValid));
endmodule

// File: rtl/irqPqController.sv
module irqPqController
  import irqPqPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IPI_NUM = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigValid,
  input  logic        trigAssert,
  input  logic [23:0] trigSrc,
  input  logic        eoiValid,
  input  logic [31:0] eoiWord,
  input  logic        restoreValid,
  input  logic [23:0] restoreSrc,
  input  logic [63:0] restoreRecord,
  input  logic [23:0] saveSrc,
  output logic [63:0] saveRecord,
  output logic        trigPresValid,
  output logic [23:0] trigPresSrc,
  output logic        eoiPresValid,
  output logic [23:0] eoiPresSrc,
  output logic        errStrobe
);
  pqStrobeT strb;

  irqPqDecode #(.NUM_SRC(NUM_SRC), .IPI_NUM(IPI_NUM)) uDecode (
    .clk(clk), .rstN(rstN),
    .trigValid(trigValid), .trigAssert(trigAssert), .trigSrc(trigSrc),
    .eoiValid(eoiValid), .eoiWord(eoiWord),
    .restoreValid(restoreValid), .restoreSrc(restoreSrc),
    .restoreRecord(restoreRecord),
    .strb(strb), .errStrobe(errStrobe)
  );

  irqPqTable #(.NUM_SRC(NUM_SRC)) uTable (
    .clk(clk), .rstN(rstN), .strb(strb),
    .saveSrc(saveSrc), .saveRecord(saveRecord),
    .trigPresValid(trigPresValid), .trigPresSrc(trigPresSrc),
    .eoiPresValid(eoiPresValid), .eoiPresSrc(eoiPresSrc)
  );
endmodule

// File: tb/tb_irqPqController.sv
`timescale 1ns/1ps
module tb_irqPqController;
  localparam int N   = 16;
  localparam int IPI = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigValid = 0, trigAssert = 0;
  logic [23:0] trigSrc = '0;
  logic        eoiValid = 0;
  logic [31:0] eoiWord = '0;
  logic        restoreValid = 0;
  logic [23:0] restoreSrc = '0;
  logic [63:0] restoreRecord = '0;
  logic [23:0] saveSrc = '0;
  logic [63:0] saveRecord;
  logic        trigPresValid, eoiPresValid, errStrobe;
  logic [23:0] trigPresSrc, eoiPresSrc;

  irqPqController #(.NUM_SRC(N), .IPI_NUM(IPI)) dut (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigAssert(trigAssert),
    .trigSrc(trigSrc), .eoiValid(eoiValid), .eoiWord(eoiWord),
    .restoreValid(restoreValid), .restoreSrc(restoreSrc),
    .restoreRecord(restoreRecord), .saveSrc(saveSrc), .saveRecord(saveRecord),
    .trigPresValid(trigPresValid), .trigPresSrc(trigPresSrc),
    .eoiPresValid(eoiPresValid), .eoiPresSrc(eoiPresSrc), .errStrobe(errStrobe)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int c; bit ch; int src; string req; } expT;
  expT expQ[$];

  bit [1:0] mPq [N];
  bit       mLvl[N];

  function automatic logic [63:0] modelRec(int s);
    logic [63:0] r = '0;
    if (s < N) begin
      r[40] = mLvl[s];
      r[42] = mLvl[s] & mPq[s][0];
      r[43] = mPq[s][0];
      r[44] = mPq[s][1];
    end
    return r;
  endfunction

  // Monitor: compare presents on both channels against the expected queue
  always @(negedge clk) if (rstN && !done) begin
    while (expQ.size() > 0 && expQ[0].c < cyc) begin
      checks++; errors++;
      $display("FAIL %s missing present ch%0d src %0d: actual none expected present",
               expQ[0].req, expQ[0].ch, expQ[0].src);
      void'(expQ.pop_front());
    end
    if (trigPresValid) begin
      checks++;
      if (expQ.size() > 0 && expQ[0].c == cyc && expQ[0].ch == 0 &&
          expQ[0].src == int'(trigPresSrc)) void'(expQ.pop_front());
      else begin
        errors++;
        $display("FAIL trigger-channel present: actual src %0d expected none", trigPresSrc);
      end
    end
    if (eoiPresValid) begin
      checks++;
      if (expQ.size() > 0 && expQ[0].c == cyc && expQ[0].ch == 1 &&
          expQ[0].src == int'(eoiPresSrc)) void'(expQ.pop_front());
      else begin
        errors++;
        $display("FAIL EOI-channel present: actual src %0d expected none", eoiPresSrc);
      end
    end
  end

  // Driver: one cycle of events; updates the model and pushes expectations
  task automatic ev(input bit tv, input bit ta, input int ts,
                    input bit ev_, input logic [31:0] ew,
                    input bit rv, input int rs, input logic [63:0] rr,
                    input string req);
    bit expErr = 0;
    bit pT = 0, pE = 0;
    int es = int'(ew[23:0]);
    bit [1:0] s;
    if (ev_ && es != IPI) begin
      if (es >= N) expErr = 1;
      else begin
        s = mPq[es];
        if (!mLvl[es]) s = s >> 1;
        mPq[es] = s;
        pE = s[0];
      end
    end
    if (tv) begin
      if (ts >= N) expErr = 1;
      else begin
        s = mPq[ts];
        if (mLvl[ts]) begin
          if (!ta) s = 2'b00;
          else if (!s[0]) begin s = 2'b01; pT = 1; end
        end else if (ta) begin
          s = {s[0], 1'b1};
          pT = (s == 2'b01);
        end
        mPq[ts] = s;
      end
    end
    if (rv) begin
      if (rs >= N) expErr = 1;
      else begin
        mLvl[rs] = rr[40];
        mPq[rs]  = {rr[44], rr[43] | rr[42]};
      end
    end
    if (pT) expQ.push_back('{cyc + 1, 1'b0, ts, req});
    if (pE) expQ.push_back('{cyc + 1, 1'b1, es, req});
    trigValid = tv; trigAssert = ta; trigSrc = 24'(ts);
    eoiValid = ev_; eoiWord = ew;
    restoreValid = rv; restoreSrc = 24'(rs); restoreRecord = rr;
    @(posedge clk);
    @(negedge clk);
    trigValid = 0; eoiValid = 0; restoreValid = 0;
    checks++;
    if (errStrobe !== expErr) begin
      errors++;
      $display("FAIL %s errStrobe: actual %0b expected %0b", req, errStrobe, expErr);
    end
  endtask

  task automatic trig(input int s, input bit a, input string req);
    ev(1, a, s, 0, 32'h0, 0, 0, 64'h0, req);
  endtask
  task automatic eoi(input logic [31:0] w, input string req);
    ev(0, 0, 0, 1, w, 0, 0, 64'h0, req);
  endtask
  task automatic rstr(input int s, input logic [63:0] r, input string req);
    ev(0, 0, 0, 0, 32'h0, 1, s, r, req);
  endtask

  task automatic checkRec(input int s, input logic [63:0] exp, input string req);
    saveSrc = 24'(s);
    #1;
    checks++;
    if (saveRecord !== exp) begin
      errors++;
      $display("FAIL %s record src %0d: actual %h expected %h", req, s, saveRecord, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mPq[i] = 0; mLvl[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    checkRec(0, 64'h0, "R1");
    checkRec(7, 64'h0, "R1");
    checkRec(N - 1, 64'h0, "R1");
    checks++;
    if (trigPresValid || eoiPresValid || errStrobe) begin
      errors++;
      $display("FAIL R1 outputs after reset: actual %b%b%b expected 000",
               trigPresValid, eoiPresValid, errStrobe);
    end

    // R2/R3: message triggers
    trig(3, 1, "R2");
    checkRec(3, 64'h0000_0800_0000_0000, "R2");
    trig(3, 1, "R3");
    checkRec(3, 64'h0000_1800_0000_0000, "R3");
    trig(3, 1, "R3");
    checkRec(3, modelRec(3), "R3");

    // R4: message EOI
    eoi(32'h0000_0003, "R4");
    checkRec(3, 64'h0000_0800_0000_0000, "R4");
    eoi(32'h0000_0003, "R4");
    checkRec(3, 64'h0, "R4");

    // R8: upper EOI bits ignored; IPI EOI has no effect
    trig(5, 1, "R8");
    eoi(32'hFF00_0005, "R8");
    checkRec(5, 64'h0, "R8");
    trig(IPI, 1, "R8");
    eoi(32'(IPI), "R8");
    checkRec(IPI, 64'h0000_0800_0000_0000, "R8");

    // R5/R7/R6/R9: level source
    rstr(7, 64'h0000_0100_0000_0000, "R10");
    checkRec(7, 64'h0000_0100_0000_0000, "R10");
    trig(7, 1, "R5");
    checkRec(7, 64'h0000_0D00_0000_0000, "R9");
    trig(7, 1, "R5");
    checkRec(7, 64'h0000_0D00_0000_0000, "R5");
    eoi(32'h0000_0007, "R7");
    checkRec(7, 64'h0000_0D00_0000_0000, "R7");
    trig(7, 0, "R6");
    checkRec(7, 64'h0000_0100_0000_0000, "R6");
    eoi(32'h0000_0007, "R7");
    checkRec(7, 64'h0000_0100_0000_0000, "R7");

    // R6: deassert on message source does nothing
    trig(3, 1, "R6");
    trig(3, 0, "R6");
    checkRec(3, 64'h0000_0800_0000_0000, "R6");

    // R10: restore decoding
    rstr(9, 64'h0000_1400_0000_0000, "R10");
    checkRec(9, 64'h0000_1800_0000_0000, "R10");
    rstr(10, 64'h0000_0900_0000_0000, "R10");
    checkRec(10, 64'h0000_0D00_0000_0000, "R10");
    checkRec(200, 64'h0, "R9");

    // R11: trigger and EOI on the same source in one cycle
    ev(1, 1, 9, 1, 32'h0000_0009, 0, 0, 64'h0, "R11");
    checkRec(9, 64'h0000_1800_0000_0000, "R11");
    trig(11, 1, "R11");
    ev(1, 1, 11, 1, 32'h0000_000B, 0, 0, 64'h0, "R11");
    checkRec(11, 64'h0000_0800_0000_0000, "R11");
    // different sources in one cycle: both channels present
    ev(1, 1, 12, 1, 32'h0000_0009, 0, 0, 64'h0, "R11");
    checkRec(9, 64'h0000_0800_0000_0000, "R11");
    checkRec(12, 64'h0000_0800_0000_0000, "R11");

    // R12: out-of-range events
    trig(20, 1, "R12");
    checkRec(4, 64'h0, "R12");
    eoi(32'h0000_0010, "R12");
    rstr(100, 64'h0000_1900_0000_0000, "R12");
    checkRec(4, 64'h0, "R12");
    checkRec(0, 64'h0, "R12");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 leftover expected presents: actual %0d expected 0", expQ.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule